// File: doc/BRIEF.md
# Serial Control Register Interface

This block is the two-wire serial slave front end of a supervisory device's single nonvolatile control register. A fixed 4-bit preamble in the upper half of the slave byte selects the register. A 9-bit register address follows: its top bit travels in bit 1 of the slave byte and its low eight bits form the next byte. A write carries exactly one data byte. That byte takes effect when the master sends a stop. The byte can do one of three things: arm the write-enable latch, arm the register-write latch, or, once both latches are armed, ask for a nonvolatile store of the five retained bits.

The store is handed off as a one-cycle request. A busy input reports the store in progress, and the fall of busy marks its completion. A read returns the whole register in one byte. The retained bits also come out as plain outputs for the watchdog and reset logic beside the block. SCL and SDA are oversampled by the system clock. SDA is driven low through an open-drain output enable.

Top module: `ctrl_reg_serial_if`

## Requirements
- R1: A slave byte whose bits [7:4] equal 4'b1011 is acknowledged, with bit 0 = 1 for read and bit 0 = 0 for write. Any other upper nibble receives no acknowledge, and SDA is not driven for the rest of that transfer.
- R2: In a write, the address byte is acknowledged only when {slave bit 1, address byte} equals 9'h1FF. Otherwise it is not acknowledged and the transfer has no effect.
- R3: A read returns one byte with the layout {PUP1, WD1, WD0, BP, 0, RWEL, WEL, PUP0}, bit 7 first, and bit 3 always 0. SDA is released after that byte. A new START is accepted without a prior STOP, either directly after the byte or after a write of slave and address bytes (random read).
- R4: A data byte with bits [2:1] = 2'b01, followed by STOP, sets WEL.
- R5: A data byte with bits [2:1] = 2'b11, followed by STOP, sets RWEL only if WEL is already 1. Otherwise it has no effect.
- R6: A data byte with bits [2:1] = 2'b00, followed by STOP while RWEL is 1, loads PUP1 = d[7], WD1 = d[6], WD0 = d[5], BP = d[4] and PUP0 = d[0], and raises `store_req_o` for exactly one clock cycle.
- R7: The same byte sent while RWEL is 0 changes no retained bit and raises no store request.
- R8: Only the first data byte of a write is acknowledged. Later bytes get no acknowledge, and the first byte still takes effect at STOP.
- R9: While `store_busy_i` is 1, the slave byte is not acknowledged.
- R10: WEL, RWEL and all retained bits are 0 after reset. WEL and RWEL clear on the clock after `store_busy_i` falls.
- R11: START and STOP are SDA edges while SCL is high, and the block changes `sda_oe_o` from 0 to 1 only while SCL is low. A repeated START before STOP discards an acknowledged but uncommitted data byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line |
| sda_i | input | 1 | Serial data line as seen on the wire |
| sda_oe_o | output | 1 | 1 pulls SDA low |
| store_busy_i | input | 1 | Nonvolatile store in progress |
| store_req_o | output | 1 | One-cycle request to store the retained bits |
| wd_sel_o | output | 2 | {WD1, WD0} |
| pup_sel_o | output | 2 | {PUP1, PUP0} |
| bp_o | output | 1 | BP bit |
| wel_o | output | 1 | Write-enable latch |
| rwel_o | output | 1 | Register-write-enable latch |

## Verification
The hardest state to reach is a slave byte that arrives while the store is still busy. Getting there requires the full three-step latch sequence, then a fresh transfer started within the busy window. The bench answers each store request with a fixed busy interval. It opens the next transfer right after the committing STOP, so the slave byte lands inside that interval. Random transactions with biased bits [2:1] then walk the latch states in many orders against a bench model of the register.

// File: rtl/cr_pkg.sv
package cr_pkg;

    typedef enum logic [1:0] {
        LS_IDLE,
        LS_RX,
        LS_ACK,
        LS_TX
    } link_state_e;

    typedef enum logic [1:0] {
        FD_SLAVE,
        FD_ADDR,
        FD_DATA
    } field_e;

    typedef struct packed {
        logic pup1;
        logic wd1;
        logic wd0;
        logic bp;
        logic pup0;
    } nv_bits_t;

    typedef struct packed {
        link_state_e st;
        field_e      fld;
        logic [3:0]  cnt;
        logic [7:0]  sh;
        logic [7:0]  tx;
        logic        rw;
        logic        a8;
        logic        got_data;
        logic        pend;
        logic [7:0]  data;
        logic        oe;
    } link_t;

    typedef struct packed {
        nv_bits_t nv;
        logic     wel;
        logic     rwel;
        logic     req;
        logic     busy_prev;
    } regs_t;

    function automatic logic [7:0] view_byte(nv_bits_t nv, logic rwel, logic wel);
        return {nv.pup1, nv.wd1, nv.wd0, nv.bp, 1'b0, rwel, wel, nv.pup0};
    endfunction

endpackage

// File: rtl/cr_pin_sync.sv
module cr_pin_sync #(
    parameter int STAGES = 2,
    parameter int LINES  = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] raw_i,
    output logic [LINES-1:0] sync_o,
    output logic [LINES-1:0] prev_o
);

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic [STAGES:0] chain_q;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= '1;
            else        chain_q <= {chain_q[STAGES-1:0], raw_i[g]};
        end

        assign sync_o[g] = chain_q[STAGES-1];
        assign prev_o[g] = chain_q[STAGES];
    end

endmodule

// File: rtl/cr_link.sv
module cr_link
    import cr_pkg::*;
#(
    parameter logic [3:0] PREAMBLE = 4'b1011,
    parameter logic [8:0] REG_ADDR = 9'h1FF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_s,
    input  logic       scl_p,
    input  logic       sda_s,
    input  logic       sda_p,
    input  logic       busy_i,
    input  logic [7:0] rd_byte_i,
    output logic       sda_oe_o,
    output logic       commit_o,
    output logic [7:0] commit_data_o
);

    localparam logic [3:0] BITS_PER_BYTE = 4'd8;

    link_t q, d;
    logic  rise, fall, start, stop, ack;

    always_comb begin
        d        = q;
        commit_o = 1'b0;
        ack      = 1'b0;
        rise     = scl_s & ~scl_p;
        fall     = ~scl_s & scl_p;
        start    = scl_s & scl_p & sda_p & ~sda_s;
        stop     = scl_s & scl_p & ~sda_p & sda_s;

        if (start) begin
            d.st       = LS_RX;
            d.fld      = FD_SLAVE;
            d.cnt      = '0;
            d.oe       = 1'b0;
            d.pend     = 1'b0;
            d.got_data = 1'b0;
        end else if (stop) begin
            commit_o   = q.pend;
            d.st       = LS_IDLE;
            d.oe       = 1'b0;
            d.pend     = 1'b0;
            d.got_data = 1'b0;
        end else begin
            unique case (q.st)
                LS_RX: begin
                    if (rise) begin
                        d.sh  = {q.sh[6:0], sda_s};
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall && q.cnt == BITS_PER_BYTE) begin
                        d.cnt = '0;
                        unique case (q.fld)
                            FD_SLAVE: begin
                                ack  = (q.sh[7:4] == PREAMBLE) && !busy_i;
                                d.rw = q.sh[0];
                                d.a8 = q.sh[1];
                            end
                            FD_ADDR: ack = ({q.a8, q.sh} == REG_ADDR);
                            default: begin
                                ack = !q.got_data;
                                if (ack) begin
                                    d.got_data = 1'b1;
                                    d.pend     = 1'b1;
                                    d.data     = q.sh;
                                end
                            end
                        endcase
                        d.oe = ack;
                        d.st = ack ? LS_ACK : LS_IDLE;
                    end
                end
                LS_ACK: begin
                    if (fall) begin
                        if (q.fld == FD_SLAVE && q.rw) begin
                            d.st  = LS_TX;
                            d.tx  = rd_byte_i;
                            d.oe  = ~rd_byte_i[7];
                            d.cnt = '0;
                        end else begin
                            d.st  = LS_RX;
                            d.oe  = 1'b0;
                            d.fld = (q.fld == FD_SLAVE) ? FD_ADDR : FD_DATA;
                        end
                    end
                end
                LS_TX: begin
                    if (rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (fall) begin
                        if (q.cnt == BITS_PER_BYTE) begin
                            d.st = LS_IDLE;
                            d.oe = 1'b0;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b0};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q     <= '0;
            q.st  <= LS_IDLE;
            q.fld <= FD_SLAVE;
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o      = q.oe;
    assign commit_data_o = q.data;

    p_oe_rise_scl_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> !scl_s);

    p_no_ack_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(q.oe) && q.st == LS_ACK && q.fld == FD_SLAVE) |-> !$past(busy_i));

endmodule

// File: rtl/cr_regfile.sv
module cr_regfile
    import cr_pkg::*;
#(
    parameter logic [4:0] NV_INIT = 5'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       commit_i,
    input  logic [7:0] commit_data_i,
    input  logic       busy_i,
    output nv_bits_t   nv_o,
    output logic       wel_o,
    output logic       rwel_o,
    output logic       store_req_o
);

    localparam logic [1:0] OP_STORE = 2'b00;
    localparam logic [1:0] OP_WEL   = 2'b01;
    localparam logic [1:0] OP_RWEL  = 2'b11;

    regs_t      q, d;
    logic [1:0] op;

    always_comb begin
        d           = q;
        d.req       = 1'b0;
        d.busy_prev = busy_i;
        op          = commit_data_i[2:1];

        if (q.busy_prev && !busy_i) begin
            d.wel  = 1'b0;
            d.rwel = 1'b0;
        end else if (commit_i) begin
            if (op == OP_STORE && q.rwel) begin
                d.nv.pup1 = commit_data_i[7];
                d.nv.wd1  = commit_data_i[6];
                d.nv.wd0  = commit_data_i[5];
                d.nv.bp   = commit_data_i[4];
                d.nv.pup0 = commit_data_i[0];
                d.req     = 1'b1;
            end else if (op == OP_WEL) begin
                d.wel = 1'b1;
            end else if (op == OP_RWEL && q.wel) begin
                d.rwel = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.nv <= NV_INIT;
        end else begin
            q <= d;
        end
    end

    assign nv_o        = q.nv;
    assign wel_o       = q.wel;
    assign rwel_o      = q.rwel;
    assign store_req_o = q.req;

    p_req_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.req |=> !q.req);

    p_req_needs_rwel_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.req) |-> $past(q.rwel));

    p_nv_only_on_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.nv != $past(q.nv)) |-> q.req);

    p_rwel_after_wel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.rwel) |-> $past(q.wel));

    p_clear_on_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (q.busy_prev && !busy_i) |=> (!q.wel && !q.rwel));

endmodule

// File: rtl/ctrl_reg_serial_if.sv
module ctrl_reg_serial_if
    import cr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter logic [3:0] PREAMBLE    = 4'b1011,
    parameter logic [8:0] REG_ADDR    = 9'h1FF,
    parameter logic [4:0] NV_INIT     = 5'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe_o,
    input  logic       store_busy_i,
    output logic       store_req_o,
    output logic [1:0] wd_sel_o,
    output logic [1:0] pup_sel_o,
    output logic       bp_o,
    output logic       wel_o,
    output logic       rwel_o
);

    localparam int LINES = 2;

    logic [LINES-1:0] line_sync, line_prev;
    logic             commit;
    logic [7:0]       commit_data;
    logic [7:0]       rd_byte;
    nv_bits_t         nv;

    cr_pin_sync #(.STAGES(SYNC_STAGES), .LINES(LINES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw_i  ({sda_i, scl_i}),
        .sync_o (line_sync),
        .prev_o (line_prev)
    );

    cr_link #(.PREAMBLE(PREAMBLE), .REG_ADDR(REG_ADDR)) i_link (
        .clk           (clk),
        .rst_n         (rst_n),
        .scl_s         (line_sync[0]),
        .scl_p         (line_prev[0]),
        .sda_s         (line_sync[1]),
        .sda_p         (line_prev[1]),
        .busy_i        (store_busy_i),
        .rd_byte_i     (rd_byte),
        .sda_oe_o      (sda_oe_o),
        .commit_o      (commit),
        .commit_data_o (commit_data)
    );

    cr_regfile #(.NV_INIT(NV_INIT)) i_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .commit_i      (commit),
        .commit_data_i (commit_data),
        .busy_i        (store_busy_i),
        .nv_o          (nv),
        .wel_o         (wel_o),
        .rwel_o        (rwel_o),
        .store_req_o   (store_req_o)
    );

    assign rd_byte   = view_byte(nv, rwel_o, wel_o);
    assign wd_sel_o  = {nv.wd1, nv.wd0};
    assign pup_sel_o = {nv.pup1, nv.pup0};
    assign bp_o      = nv.bp;

endmodule

// File: tb/test_ctrl_reg_serial_if.sv
module test_ctrl_reg_serial_if;

    localparam int BUSY_CYC = 300;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic busy = 1'b0;
    logic sda_oe, store_req, bp, wel, rwel;
    logic [1:0] wd_sel, pup_sel;
    wire  sda_line = sda_m & ~sda_oe;

    int errors = 0;
    int checks = 0;
    int nstore = 0;
    int busy_cnt = 0;
    bit done = 0;

    logic       e_wel = 0, e_rwel = 0;
    logic [4:0] e_nv = '0;  // {pup1, wd1, wd0, bp, pup0}
    int         e_nstore = 0;

    always #2.5 clk = ~clk;

    ctrl_reg_serial_if i_ctrl_reg_serial_if (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
        .sda_oe_o(sda_oe), .store_busy_i(busy), .store_req_o(store_req),
        .wd_sel_o(wd_sel), .pup_sel_o(pup_sel), .bp_o(bp),
        .wel_o(wel), .rwel_o(rwel)
    );

    always @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0; busy_cnt <= 0;
        end else if (store_req) begin
            busy <= 1'b1; busy_cnt <= BUSY_CYC; nstore <= nstore + 1;
        end else if (busy_cnt > 0) begin
            busy_cnt <= busy_cnt - 1;
        end else begin
            busy <= 1'b0;
        end
    end

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    function automatic logic [7:0] exp_byte();
        return {e_nv[4], e_nv[3], e_nv[2], e_nv[1], 1'b0, e_rwel, e_wel, e_nv[0]};
    endfunction

    task automatic bus_start();
        sda_m = 1; wait_clk(4); scl_m = 1; wait_clk(4);
        sda_m = 0; wait_clk(4); scl_m = 0; wait_clk(4);
    endtask

    task automatic bus_stop();
        sda_m = 0; wait_clk(4); scl_m = 1; wait_clk(4); sda_m = 1; wait_clk(4);
    endtask

    task automatic put_bit(input logic b);
        sda_m = b; wait_clk(4); scl_m = 1; wait_clk(8); scl_m = 0; wait_clk(4);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1; wait_clk(4); scl_m = 1; wait_clk(4); b = sda_line;
        wait_clk(4); scl_m = 0; wait_clk(4);
    endtask

    task automatic put_byte(input logic [7:0] v, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        acked = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin get_bit(b); v[i] = b; end
        put_bit(1'b1);
    endtask

    task automatic check_ports(input string req);
        chk({req, " wel"}, wel, e_wel);
        chk({req, " rwel"}, rwel, e_rwel);
        chk({req, " nv"}, {pup_sel[1], wd_sel, bp, pup_sel[0]}, e_nv);
    endtask

    task automatic model_commit(input logic [7:0] d);
        if (d[2:1] == 2'b00 && e_rwel) begin
            e_nv = {d[7], d[6], d[5], d[4], d[0]};
            e_nstore++;
        end else if (d[2:1] == 2'b01) begin
            e_wel = 1;
        end else if (d[2:1] == 2'b11 && e_wel) begin
            e_rwel = 1;
        end
    endtask

    task automatic settle_store();
        wait_clk(10);
        chk("R6 store pulses", nstore, e_nstore);
        if (busy) begin
            while (busy) wait_clk(1);
            wait_clk(4);
            e_wel = 0; e_rwel = 0;
        end
    endtask

    task automatic reg_write(input logic [7:0] d, input string req);
        logic a0, a1, a2;
        bus_start(); put_byte(8'hB2, a0); put_byte(8'hFF, a1); put_byte(d, a2); bus_stop();
        chk({req, " write acks"}, {a0, a1, a2}, 3'b111);
        model_commit(d);
        settle_store();
        check_ports(req);
    endtask

    task automatic reg_read(input string req);
        logic a; logic [7:0] v;
        bus_start(); put_byte(8'hB3, a); get_byte(v); bus_stop();
        chk({req, " read ack"}, a, 1'b1);
        chk({req, " read byte"}, v, exp_byte());
        wait_clk(4);
    endtask

    initial begin
        wait_clk(150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        logic a, a1, a2;
        logic [7:0] v, v2;
        void'($urandom(32'h1D5E_ED01));
        wait_clk(5);
        rst_n = 1;
        wait_clk(5);

        // R10 reset state
        check_ports("R10 reset");
        chk("R10 reset oe/req", {sda_oe, store_req}, 2'b00);
        reg_read("R3 reset");

        // R7 store without RWEL ignored
        reg_write(8'hF1, "R7 no rwel");
        reg_read("R7 after");
        // R5 RWEL without WEL ignored
        reg_write(8'h06, "R5 no wel");
        // R4 / R5 latch sequence
        reg_write(8'h02, "R4 wel");
        reg_read("R4 view");
        reg_write(8'h06, "R5 rwel");
        reg_read("R5 view");

        // R6 store, then R9 busy nack right after
        bus_start(); put_byte(8'hB2, a); put_byte(8'hFF, a1); put_byte(8'hE9, a2); bus_stop();
        chk("R6 store acks", {a, a1, a2}, 3'b111);
        model_commit(8'hE9);
        wait_clk(6);
        chk("R9 busy during store", busy, 1'b1);
        bus_start(); put_byte(8'hB3, a); bus_stop();
        chk("R9 slave nack while busy", a, 1'b0);
        settle_store();
        check_ports("R10 cleared after store");
        reg_read("R3 bit3 zero");

        // R1 bad preamble
        bus_start(); put_byte(8'hA2, a); bus_stop();
        chk("R1 bad preamble nack", a, 1'b0);
        // R2 bad address bit 8, then bad low byte
        bus_start(); put_byte(8'hB0, a); put_byte(8'hFF, a1); put_byte(8'h02, a2); bus_stop();
        chk("R2 a8=0 acks", {a, a1}, 2'b10);
        bus_start(); put_byte(8'hB2, a); put_byte(8'hFE, a1); put_byte(8'h02, a2); bus_stop();
        chk("R2 FE acks", {a, a1}, 2'b10);
        wait_clk(8);
        check_ports("R2 no effect");

        // R8 two data bytes
        bus_start(); put_byte(8'hB2, a); put_byte(8'hFF, a1); put_byte(8'h02, a2);
        put_byte(8'h06, v[0]); bus_stop();
        chk("R8 first acked", {a, a1, a2}, 3'b111);
        chk("R8 second nacked", v[0], 1'b0);
        model_commit(8'h02);
        settle_store();
        check_ports("R8 first byte used");

        // R11 repeated start discards the pending byte
        bus_start(); put_byte(8'hB2, a); put_byte(8'hFF, a1); put_byte(8'h06, a2);
        bus_start(); put_byte(8'hB3, a); get_byte(v); bus_stop();
        chk("R11 read after restart", v, exp_byte());
        wait_clk(10);
        check_ports("R11 pending discarded");

        // R3 random read and back-to-back reads with no stop
        bus_start(); put_byte(8'hB2, a); put_byte(8'hFF, a1);
        bus_start(); put_byte(8'hB3, a2); get_byte(v);
        bus_start(); put_byte(8'hB3, a); get_byte(v2); bus_stop();
        chk("R3 random read", v, exp_byte());
        chk("R3 second read without stop", v2, exp_byte());
        chk("R3 acks", {a1, a2, a}, 3'b111);
        wait_clk(6);
        chk("R3 released", sda_oe, 1'b0);

        // random mix
        for (int it = 0; it < 40; it++) begin
            int op;
            logic [7:0] d;
            op = $urandom_range(0, 5);
            d  = 8'($urandom);
            case ($urandom_range(0, 3))
                0: d[2:1] = 2'b00;
                1: d[2:1] = 2'b01;
                2: d[2:1] = 2'b11;
                default: d[2:1] = 2'b10;
            endcase
            case (op)
                0, 1, 2: reg_write(d, "R6 random write");
                3: reg_read("R3 random read");
                4: begin
                    v = {4'($urandom_range(0, 10)), 4'($urandom)};
                    bus_start(); put_byte(v, a); bus_stop();
                    chk("R1 random preamble", a, 1'b0);
                    wait_clk(4);
                end
                default: begin
                    bus_start(); put_byte(8'hB2, a); put_byte(8'hFF, a1); put_byte(d, a2);
                    put_byte(~d, v[0]); bus_stop();
                    chk("R8 random extra nack", {a2, v[0]}, 2'b10);
                    model_commit(d);
                    settle_store();
                    check_ports("R8 random");
                end
            endcase
        end

        done = 1;
        summary();
        $finish;
    end

endmodule